// File: doc/BRIEF.md
# Half-Bridge Leg Controller with Dead-Time Insertion

This block turns a pair of symmetric active-high command inputs and an active-low stop input into the gate enables for the high-side and low-side switches of one half-bridge leg. The two commands are combined with a logical AND. When both are high, the leg drives its output high. When either one is low, the low-side switch is turned on, which gives a brake with slow current decay. Each command can therefore serve as either the direction select or the brake, and the two are fully interchangeable.

Between the turn-off of one switch and the turn-on of the other, the controller keeps both enables low for a programmable number of clock cycles. Two undervoltage-lockout trackers, one for the low-side supply and one for the floating high-side supply, add hysteresis to digital threshold flags. They suppress the outputs while a supply is not valid. A third output enables the bootstrap charging switch, and it follows the low-side enable.

All outputs are registered. The stop input and the low-side lockout act on the first clock edge that samples them. When they are released, the outputs resume only after a dead-time count with both enables low.

Top module: `hbleg_ctrl`

## Requirements
- R1: While reset is asserted, hs_gate_o, ls_gate_o and boot_chg_o are 0, and both supplies are treated as locked out. After reset, the first enable rises only after a full dead-time count, exactly as in R11.
- R2: With no stop and no lockout, once settled, cmd_x_i=1 and cmd_y_i=1 give hs_gate_o=1 and ls_gate_o=0. Any other command pair gives hs_gate_o=0 and ls_gate_o=1.
- R3: While cmd_y_i is 0, the leg settles with the low side on and the high side off, and changes of cmd_x_i have no effect on any output.
- R4: cmd_x_i and cmd_y_i are interchangeable: the pairs (1,0) and (0,1) give the same outputs, the low side on.
- R5: A 0 on stop_n_i forces hs_gate_o and ls_gate_o to 0 from the first clock edge that samples it, and keeps them there while it stays 0.
- R6: On a handover between the high side and the low side, in either direction, both enables are 0 for exactly dead_cycles_i+1 clock cycles. dead_cycles_i is a 10-bit unsigned count.
- R7: With dead_cycles_i=0, a handover keeps both enables 0 for exactly one cycle.
- R8: The low-side lockout is entered when vlo_above_off_i is 0, and is left only when vlo_above_on_i is 1. While it is locked, both enables are 0. While it is unlocked, vlo_above_on_i=0 with vlo_above_off_i=1 keeps it unlocked.
- R9: The high-side lockout uses the same hysteresis on vhi_above_on_i and vhi_above_off_i. While it is locked, hs_gate_o is 0. A request for the high side then leaves both enables 0, and a request for the low side is served normally.
- R10: boot_chg_o equals ls_gate_o in every cycle.
- R11: When stop or low-side lockout is released, or when a high-side lockout that was blocking a high-side request clears, with edge r the first clock edge that samples the release, the requested enable rises at edge r+dead_cycles_i.
- R12: hs_gate_o and ls_gate_o are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_x_i | input | 1 | Command input A, active high |
| cmd_y_i | input | 1 | Command input B, active high; a low forces the low side (brake) |
| stop_n_i | input | 1 | Stop, active low; forces both enables off |
| dead_cycles_i | input | 10 | Dead-time count in clock cycles |
| vlo_above_on_i | input | 1 | Low-side supply is above its turn-on threshold |
| vlo_above_off_i | input | 1 | Low-side supply is above its turn-off threshold |
| vhi_above_on_i | input | 1 | Floating supply is above its turn-on threshold |
| vhi_above_off_i | input | 1 | Floating supply is above its turn-off threshold |
| hs_gate_o | output | 1 | High-side gate enable |
| ls_gate_o | output | 1 | Low-side gate enable |
| boot_chg_o | output | 1 | Bootstrap charging switch enable |

## Verification
Each result has a fixed due cycle, counted in rising edges from the falling edge where the stimulus is applied:
- A stop or a low-side lockout shows at edge 1.
- A handover shows both enables low from edge 1, with the new enable at edge dead+2.
- A release shows its enable at edge dead+1.

The driver turns each of these counts into a due cycle and queues the expected enable pair with that cycle. The monitor compares only on falling edges, and only against items whose due cycle has arrived. It also compares the bootstrap enable with the expected low-side value and checks that the two enables are never both high. The counts are computed from the requirements, not from the design state.

// File: rtl/hbleg_pkg.sv
package hbleg_pkg;

    typedef enum logic [1:0] {
        LEG_OFF  = 2'd0,
        LEG_HIGH = 2'd1,
        LEG_LOW  = 2'd2
    } leg_mode_e;

    localparam int unsigned LEG_SUPPLIES = 2;
    localparam int unsigned SUP_LOW      = 0;
    localparam int unsigned SUP_HIGH     = 1;

endpackage

// File: rtl/hbleg_uvlo.sv
module hbleg_uvlo #(
    parameter logic LOCK_AT_RESET = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic above_on_i,
    input  logic above_off_i,
    output logic lock_next_o
);

    typedef struct packed {
        logic lock;
    } uv_state_t;

    uv_state_t uv_d, uv_q;

    always_comb begin
        uv_d = uv_q;
        if (uv_q.lock) begin
            if (above_on_i) begin
                uv_d.lock = 1'b0;
            end
        end else if (!above_off_i) begin
            uv_d.lock = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            uv_q.lock <= LOCK_AT_RESET;
        end else begin
            uv_q <= uv_d;
        end
    end

    assign lock_next_o = uv_d.lock;

    AST_UV_STAYS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_q.lock && !above_on_i) |=> uv_q.lock); // R8

    AST_UV_STAYS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!uv_q.lock && above_off_i) |=> !uv_q.lock); // R8

endmodule

// File: rtl/hbleg_decode.sv
module hbleg_decode
    import hbleg_pkg::*;
(
    input  logic      cmd_x_i,
    input  logic      cmd_y_i,
    input  logic      hv_lock_i,
    output leg_mode_e target_o
);

    logic drive_high;

    always_comb begin
        drive_high = cmd_x_i & cmd_y_i;
        if (!drive_high) begin
            target_o = LEG_LOW;
        end else if (hv_lock_i) begin
            target_o = LEG_OFF;
        end else begin
            target_o = LEG_HIGH;
        end
    end

endmodule

// File: rtl/hbleg_deadtime.sv
module hbleg_deadtime
    import hbleg_pkg::*;
#(
    parameter int unsigned DT_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            kill_i,
    input  leg_mode_e       target_i,
    input  logic [DT_W-1:0] dead_i,
    output logic            hs_o,
    output logic            ls_o,
    output logic            boot_o
);

    typedef struct packed {
        leg_mode_e       mode;
        logic [DT_W-1:0] cnt;
        logic            hs;
        logic            ls;
        logic            boot;
    } leg_state_t;

    leg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (kill_i) begin
            st_d.mode = LEG_OFF;
            st_d.cnt  = '0;
        end else begin
            case (st_q.mode)
                LEG_HIGH, LEG_LOW: begin
                    if (target_i != st_q.mode) begin
                        st_d.mode = LEG_OFF;
                        st_d.cnt  = '0;
                    end
                end
                default: begin
                    if (target_i == LEG_OFF) begin
                        st_d.cnt = '0;
                    end else if (st_q.cnt >= dead_i) begin
                        st_d.mode = target_i;
                        st_d.cnt  = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            endcase
        end
        st_d.hs   = (st_d.mode == LEG_HIGH);
        st_d.ls   = (st_d.mode == LEG_LOW);
        st_d.boot = (st_d.mode == LEG_LOW);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode <= LEG_OFF;
            st_q.cnt  <= '0;
            st_q.hs   <= 1'b0;
            st_q.ls   <= 1'b0;
            st_q.boot <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hs_o   = st_q.hs;
    assign ls_o   = st_q.ls;
    assign boot_o = st_q.boot;

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.hs && st_q.ls)); // R12

    AST_KILL_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
        kill_i |=> (!st_q.hs && !st_q.ls)); // R5

    AST_BOOT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.boot == st_q.ls); // R10

    AST_GAP_TO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ls) |-> !$past(st_q.hs)); // R6

    AST_GAP_TO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.hs) |-> !$past(st_q.ls)); // R7

endmodule

// File: rtl/hbleg_ctrl.sv
module hbleg_ctrl
    import hbleg_pkg::*;
#(
    parameter int unsigned DT_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_x_i,
    input  logic            cmd_y_i,
    input  logic            stop_n_i,
    input  logic [DT_W-1:0] dead_cycles_i,
    input  logic            vlo_above_on_i,
    input  logic            vlo_above_off_i,
    input  logic            vhi_above_on_i,
    input  logic            vhi_above_off_i,
    output logic            hs_gate_o,
    output logic            ls_gate_o,
    output logic            boot_chg_o
);

    logic [LEG_SUPPLIES-1:0] above_on;
    logic [LEG_SUPPLIES-1:0] above_off;
    logic [LEG_SUPPLIES-1:0] lock_next;
    logic                    kill;
    leg_mode_e               target;

    assign above_on[SUP_LOW]   = vlo_above_on_i;
    assign above_off[SUP_LOW]  = vlo_above_off_i;
    assign above_on[SUP_HIGH]  = vhi_above_on_i;
    assign above_off[SUP_HIGH] = vhi_above_off_i;

    for (genvar g = 0; g < LEG_SUPPLIES; g++) begin : g_uvlo
        hbleg_uvlo #(
            .LOCK_AT_RESET(1'b1)
        ) u_uvlo (
            .clk         (clk),
            .rst_n       (rst_n),
            .above_on_i  (above_on[g]),
            .above_off_i (above_off[g]),
            .lock_next_o (lock_next[g])
        );
    end

    assign kill = !stop_n_i || lock_next[SUP_LOW];

    hbleg_decode u_decode (
        .cmd_x_i   (cmd_x_i),
        .cmd_y_i   (cmd_y_i),
        .hv_lock_i (lock_next[SUP_HIGH]),
        .target_o  (target)
    );

    hbleg_deadtime #(
        .DT_W(DT_W)
    ) u_deadtime (
        .clk      (clk),
        .rst_n    (rst_n),
        .kill_i   (kill),
        .target_i (target),
        .dead_i   (dead_cycles_i),
        .hs_o     (hs_gate_o),
        .ls_o     (ls_gate_o),
        .boot_o   (boot_chg_o)
    );

    AST_HV_LOCK_BLOCKS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        lock_next[SUP_HIGH] |=> !hs_gate_o); // R9

    AST_CMD_LOW_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_x_i || !cmd_y_i) |=> !hs_gate_o); // R3

endmodule

// File: tb/hbleg_ctrl_bench.sv
module hbleg_ctrl_bench;

    localparam int DT_W = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cmd_x = 1'b0;
    logic            cmd_y = 1'b1;
    logic            stop_n = 1'b1;
    logic [DT_W-1:0] dead = 10'd3;
    logic            vlo_on = 1'b1;
    logic            vlo_off = 1'b1;
    logic            vhi_on = 1'b1;
    logic            vhi_off = 1'b1;
    logic            hs, ls, boot;

    always #10 clk = ~clk;

    hbleg_ctrl #(.DT_W(DT_W)) u_hbleg_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .cmd_x_i         (cmd_x),
        .cmd_y_i         (cmd_y),
        .stop_n_i        (stop_n),
        .dead_cycles_i   (dead),
        .vlo_above_on_i  (vlo_on),
        .vlo_above_off_i (vlo_off),
        .vhi_above_on_i  (vhi_on),
        .vhi_above_off_i (vhi_off),
        .hs_gate_o       (hs),
        .ls_gate_o       (ls),
        .boot_chg_o      (boot)
    );

    typedef struct {
        int    due;
        logic  exp_hs;
        logic  exp_ls;
        string tag;
    } exp_item_t;

    exp_item_t sb_q[$];
    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic expect_in(input int n, input logic e_hs, input logic e_ls, input string tag);
        exp_item_t it;
        it.due    = cyc + n;
        it.exp_hs = e_hs;
        it.exp_ls = e_ls;
        it.tag    = tag;
        sb_q.push_back(it);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops due items and compares on falling edges
    always @(negedge clk) begin
        checks++;
        if (hs && ls) begin
            errors++;
            $display("FAIL R12: both enables high, hs=%0b ls=%0b expected not both", hs, ls);
        end
        while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
            exp_item_t it;
            it = sb_q.pop_front();
            checks++;
            if (hs !== it.exp_hs || ls !== it.exp_ls) begin
                errors++;
                $display("FAIL %s: hs=%0b ls=%0b expected hs=%0b ls=%0b (cycle %0d)",
                         it.tag, hs, ls, it.exp_hs, it.exp_ls, cyc);
            end
            checks++;
            if (boot !== it.exp_ls) begin
                errors++;
                $display("FAIL R10 (%s): boot=%0b expected %0b", it.tag, boot, it.exp_ls);
            end
        end
    end

    initial begin
        wait_cyc(3);
        checks++;
        if (hs !== 1'b0 || ls !== 1'b0 || boot !== 1'b0) begin
            errors++;
            $display("FAIL R1: reset hs=%0b ls=%0b boot=%0b expected 0 0 0", hs, ls, boot);
        end
        rst_n = 1'b1;
        // r1_ startup: low side after dead time of 3
        expect_in(3, 1'b0, 1'b0, "R1 off during startup count");
        expect_in(4, 1'b0, 1'b1, "R11 low side after startup count");
        wait_cyc(6);

        cmd_x = 1'b1;
        expect_in(1, 1'b0, 1'b0, "R6 low to high blank start");
        expect_in(4, 1'b0, 1'b0, "R6 low to high blank end");
        expect_in(5, 1'b1, 1'b0, "R2 both commands high");
        wait_cyc(7);

        cmd_x = 1'b0;
        expect_in(1, 1'b0, 1'b0, "R6 high to low blank start");
        expect_in(4, 1'b0, 1'b0, "R6 high to low blank end");
        expect_in(5, 1'b0, 1'b1, "R2 command x low");
        wait_cyc(7);

        cmd_x = 1'b1;
        expect_in(5, 1'b1, 1'b0, "R2 high again");
        wait_cyc(7);
        cmd_y = 1'b0;
        expect_in(1, 1'b0, 1'b0, "R3 brake blank");
        expect_in(5, 1'b0, 1'b1, "R3 brake low side");
        wait_cyc(6);
        cmd_x = 1'b0;
        expect_in(2, 1'b0, 1'b1, "R3 x toggle ignored under brake");
        wait_cyc(3);
        cmd_x = 1'b1;
        expect_in(2, 1'b0, 1'b1, "R3 x toggle ignored under brake");
        wait_cyc(3);

        cmd_x = 1'b0;
        cmd_y = 1'b1;
        expect_in(3, 1'b0, 1'b1, "R4 swapped pair same output");
        wait_cyc(3);
        cmd_x = 1'b1;
        expect_in(5, 1'b1, 1'b0, "R4 pair 1,1 after swap");
        wait_cyc(7);

        dead = 10'd0;
        cmd_y = 1'b0;
        expect_in(1, 1'b0, 1'b0, "R7 zero dead one blank cycle");
        expect_in(2, 1'b0, 1'b1, "R7 zero dead low side");
        wait_cyc(3);
        cmd_y = 1'b1;
        expect_in(1, 1'b0, 1'b0, "R7 zero dead one blank cycle");
        expect_in(2, 1'b1, 1'b0, "R7 zero dead high side");
        wait_cyc(3);

        dead = 10'd2;
        stop_n = 1'b0;
        expect_in(1, 1'b0, 1'b0, "R5 stop immediate");
        expect_in(4, 1'b0, 1'b0, "R5 stop held");
        wait_cyc(5);
        stop_n = 1'b1;
        expect_in(2, 1'b0, 1'b0, "R11 stop release count");
        expect_in(3, 1'b1, 1'b0, "R11 stop release resume");
        wait_cyc(5);

        vlo_on = 1'b0;
        vlo_off = 1'b0;
        expect_in(1, 1'b0, 1'b0, "R8 low supply lockout");
        wait_cyc(2);
        vlo_off = 1'b1;
        expect_in(5, 1'b0, 1'b0, "R8 stays locked between thresholds");
        wait_cyc(5);
        vlo_on = 1'b1;
        expect_in(2, 1'b0, 1'b0, "R8 release count");
        expect_in(3, 1'b1, 1'b0, "R8 resume after release");
        wait_cyc(5);
        vlo_on = 1'b0;
        expect_in(4, 1'b1, 1'b0, "R8 stays unlocked between thresholds");
        wait_cyc(4);
        vlo_on = 1'b1;

        cmd_y = 1'b0;
        expect_in(4, 1'b0, 1'b1, "R9 setup low side");
        wait_cyc(4);
        vhi_on = 1'b0;
        vhi_off = 1'b0;
        expect_in(3, 1'b0, 1'b1, "R9 low side unaffected by high lockout");
        wait_cyc(3);
        cmd_y = 1'b1;
        expect_in(1, 1'b0, 1'b0, "R9 high request blocked");
        expect_in(6, 1'b0, 1'b0, "R9 high request still blocked");
        wait_cyc(6);
        vhi_off = 1'b1;
        expect_in(4, 1'b0, 1'b0, "R9 stays locked between thresholds");
        wait_cyc(4);
        vhi_on = 1'b1;
        expect_in(2, 1'b0, 1'b0, "R11 high lockout release count");
        expect_in(3, 1'b1, 1'b0, "R9 high side after release");
        wait_cyc(5);

        while (sb_q.size() > 0) wait_cyc(1);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not end, pending=%0d expected 0", sb_q.size());
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule